// File: doc/BRIEF.md
# ADC Channel Sequencer with Sample FIFO

This block controls an external successive-approximation converter from a small register file. Software writes a packed table of byte-wide entries. Each entry holds a channel number and an end-of-sequence flag. A command word then starts a walk over that table. For each entry the block raises a start strobe toward the converter with the channel and resolution selects, and waits for the converter's done strobe. It then pushes the result into a 32-deep sample FIFO, waits a programmed number of microsecond ticks, and moves to the next entry.

A single command walks the table once and then flags completion. A continuous command keeps looping over the table until a stop command arrives. Status bits report completion, continuous-pass completion and FIFO overflow. Software clears these bits by writing ones. A level interrupt is formed from the status and enable bits. Software drains the FIFO by reading the sample port, and empties it at once by writing all ones to that port.

The register bus uses word indices: 0 to 7 are table words, 8 is the command, 9 is status, 10 is enable, 11 is the sample port and 12 is the fill count. Reads are combinational. A read of index 11 pops one sample.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset the fill count reads 0, `irq` is low, `conv_start` is low and all status bits are 0.
- R2: Table entry k is byte k mod 4 of word k/4, counting from the low byte. `conv_chan` carries bits 4:0 of the current entry. A walk starts at entry 0, and a single walk ends after converting an entry whose bit 7 is 1.
- R3: Command bits 8:4 hold a sample limit L. A walk converts at most L+1 entries even if no entry carries the end flag.
- R4: Command bits 31:24 hold a spacing S. `conv_start` is a one-cycle pulse. Within a walk it rises S*TICK_DIV+1 cycles after the cycle in which `conv_done` was high; with S=0 that is the next cycle.
- R5: Command bits 15:14 hold a resolution code r that drives `conv_res`. Code 0 is 6 bits, 1 is 8 bits, 2 is 10 bits and 3 is 12 bits. The stored sample is `conv_result` shifted right by 2*(3-r).
- R6: The FIFO holds 32 samples and is read in arrival order at index 11; each read pops one. Index 12 reads the fill level. A read of an empty FIFO changes nothing.
- R7: Writing 32'hFFFFFFFF to index 11 empties the FIFO, and the count reads 0 on the following cycle.
- R8: A conversion that finishes while the FIFO holds 32 samples is dropped and sets status bit 1.
- R9: Status bit 0 means command complete, bit 1 means overflow and bit 2 means continuous pass complete. Writing 1 to a bit at index 9 clears it.
- R10: Opcode 1 (command bits 2:0) repeats the walk, setting bit 2 after each pass. Opcode 5 while busy aborts the walk at once and sets bit 0.
- R11: Opcode 0 starts a single walk that sets bit 0 when done. Any opcode other than 0 or 1 written while idle sets bit 0 at once. While busy, every command except opcode 5 is ignored.
- R12: `irq` = (st0 & en0 & ie) | (st1 & en1) | (st2 & en2 & ie). Here en is the word at index 10 and ie is bit 3 of the last accepted command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops at index 11) |
| reg_addr | input | 4 | Register word index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational |
| irq | output | 1 | Interrupt level |
| conv_start | output | 1 | Converter start pulse |
| conv_chan | output | 5 | Converter channel select |
| conv_res | output | 2 | Converter resolution code |
| conv_done | input | 1 | Converter done pulse |
| conv_result | input | 12 | Converter result |

## Verification
The assertions assume that the converter raises `conv_done` only once per `conv_start`, and only while the block is waiting for it. They also assume that the table is not rewritten during a walk. The behavioural converter stub answers each start pulse after a fixed latency with a single done pulse. The bench leaves the table untouched while a command runs, and waits well beyond the stub latency after a stop before it issues the next command. This keeps stray done pulses from aborted conversions outside any walk.

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
  parameter int TICK_DIV = 4,
  parameter int DEPTH = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [3:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq,
  output logic        conv_start,
  output logic [4:0]  conv_chan,
  output logic [1:0]  conv_res,
  input  logic        conv_done,
  input  logic [11:0] conv_result
);
  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  typedef enum logic [1:0] {IDLE, START, WAIT, SPACE} state_t;
  state_t state;

  logic [31:0] tbl [8];
  logic [31:0] cmd_q;
  logic        cont;
  logic [4:0]  idx, n;
  logic [PW-1:0] presc;
  logic [7:0]  us;
  logic [2:0]  status, enable;
  logic [11:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  logic [7:0]  entry, spacing;
  logic [4:0]  ns;
  logic [1:0]  res;
  logic        ie, busy, cmd_wr, go, imm, stop, push, last, full, wr_ok, pop, flush;
  logic [11:0] sample;
  logic [2:0]  st_set, st_clr;

  assign spacing = cmd_q[31:24];
  assign res     = cmd_q[15:14];
  assign ns      = cmd_q[8:4];
  assign ie      = cmd_q[3];
  assign entry   = tbl[idx[4:2]][{idx[1:0], 3'b000} +: 8];

  assign busy   = state != IDLE;
  assign cmd_wr = reg_wr && reg_addr == 4'd8;
  assign go     = cmd_wr && !busy && reg_wdata[2:1] == 2'b00;
  assign imm    = cmd_wr && !busy && reg_wdata[2:1] != 2'b00;
  assign stop   = cmd_wr && busy && reg_wdata[2:0] == 3'd5;
  assign push   = state == WAIT && conv_done;
  assign last   = entry[7] || n == ns;
  assign full   = cnt == CW'(DEPTH);
  assign wr_ok  = push && !full;
  assign pop    = reg_rd && reg_addr == 4'd11 && cnt != '0;
  assign flush  = reg_wr && reg_addr == 4'd11 && reg_wdata == 32'hFFFF_FFFF;
  assign sample = conv_result >> {~res, 1'b0};

  assign conv_start = state == START;
  assign conv_chan  = entry[4:0];
  assign conv_res   = res;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= IDLE;
      cmd_q <= '0;
      cont  <= 1'b0;
      idx   <= '0;
      n     <= '0;
      presc <= '0;
      us    <= '0;
    end else if (go) begin
      state <= START;
      cmd_q <= reg_wdata;
      cont  <= reg_wdata[0];
      idx   <= '0;
      n     <= '0;
    end else if (imm) begin
      cmd_q <= reg_wdata;
    end else if (stop) begin
      state <= IDLE;
    end else begin
      case (state)
        START: state <= WAIT;
        WAIT: if (conv_done) begin
          presc <= '0;
          us    <= '0;
          idx   <= last ? 5'd0 : idx + 5'd1;
          n     <= last ? 5'd0 : n + 5'd1;
          if (last && !cont) state <= IDLE;
          else state <= (spacing == 8'd0) ? START : SPACE;
        end
        SPACE: if (presc == PW'(TICK_DIV - 1)) begin
          presc <= '0;
          if (us == spacing - 8'd1) state <= START;
          else us <= us + 8'd1;
        end else begin
          presc <= presc + PW'(1);
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) tbl[i] <= '0;
      enable <= '0;
    end else if (reg_wr) begin
      if (!reg_addr[3]) tbl[reg_addr[2:0]] <= reg_wdata;
      if (reg_addr == 4'd10) enable <= reg_wdata[2:0];
    end
  end

  assign st_set = {push && last && cont, push && full, (push && last && !cont) || stop || imm};
  assign st_clr = (reg_wr && reg_addr == 4'd9) ? reg_wdata[2:0] : 3'b000;

  always_ff @(posedge clk) begin
    if (!rst_n) status <= '0;
    else status <= (status & ~st_clr) | st_set;
  end

  always_ff @(posedge clk) begin
    if (wr_ok && !flush) mem[wp] <= sample;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (wr_ok) wp <= wp + AW'(1);
      if (pop) rp <= rp + AW'(1);
      cnt <= cnt + CW'(wr_ok) - CW'(pop);
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (!reg_addr[3]) reg_rdata = tbl[reg_addr[2:0]];
    else case (reg_addr)
      4'd8:  reg_rdata = cmd_q;
      4'd9:  reg_rdata = {29'd0, status};
      4'd10: reg_rdata = {29'd0, enable};
      4'd11: reg_rdata = {20'd0, mem[rp]};
      4'd12: reg_rdata = {{(32-CW){1'b0}}, cnt};
      default: reg_rdata = '0;
    endcase
  end

  assign irq = |(status & enable & {ie, 1'b1, ie});

  // R4
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);
  // R6
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
  // R7
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> cnt == '0);
  // R8
  ovf_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full) |=> status[1]);
  // R9
  w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 4'd9 && reg_wdata[0] && !push) |=> !status[0]);
  // R10
  pass_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[2]) |-> $past(conv_done));
endmodule

// File: tb/sim_adc_seq_ctrl.sv
`timescale 1ns/1ps
module sim_adc_seq_ctrl;
  localparam int DIV = 4;
  logic clk = 0, rst_n = 0;
  logic reg_wr = 0, reg_rd = 0;
  logic [3:0] reg_addr = 4'd12;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic irq, conv_start, conv_done = 0;
  logic [4:0] conv_chan;
  logic [1:0] conv_res;
  logic [11:0] conv_result = 0;

  adc_seq_ctrl #(.TICK_DIV(DIV), .DEPTH(32)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .conv_start(conv_start),
    .conv_chan(conv_chan), .conv_res(conv_res), .conv_done(conv_done), .conv_result(conv_result));

  always #2 clk = ~clk;

  int tests = 0, fails = 0;
  task automatic chk(input bit ok, input string name, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", name, act, exp);
    end
  endtask

  // reference model
  logic [7:0] tm [32];
  int q[$];
  int m_mode = 0, m_idx = 0, m_n = 0, m_ns = 0, m_res = 0, m_sp = 0;
  bit m_ie = 0;
  logic [2:0] m_st = 0, m_en = 0;
  int mode_pre, v, op;
  bit full_b, psh, lst;

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); m_mode = 0; m_st = 0; m_en = 0; m_ie = 0; m_idx = 0; m_n = 0;
      for (int k = 0; k < 32; k++) tm[k] = 0;
    end else begin
      mode_pre = m_mode;
      full_b = q.size() >= 32;
      psh = (m_mode != 0) && conv_done;
      v = int'(conv_result) >> (2 * (3 - m_res));
      if (reg_wr && reg_addr == 4'd11 && reg_wdata == 32'hFFFF_FFFF) q.delete();
      else begin
        if (reg_rd && reg_addr == 4'd11 && q.size() > 0) void'(q.pop_front());
        if (psh && !full_b) q.push_back(v);
      end
      if (psh) begin
        if (full_b) m_st[1] = 1;
        lst = tm[m_idx][7] || m_n == m_ns;
        if (lst) begin
          m_idx = 0; m_n = 0;
          if (m_mode == 1) begin m_st[0] = 1; m_mode = 0; end
          else m_st[2] = 1;
        end else begin m_idx++; m_n++; end
      end
      if (reg_wr && reg_addr == 4'd9) m_st = m_st & ~reg_wdata[2:0];
      if (reg_wr && reg_addr == 4'd10) m_en = reg_wdata[2:0];
      if (reg_wr && reg_addr < 4'd8)
        for (int k = 0; k < 4; k++) tm[reg_addr*4 + k] = reg_wdata[k*8 +: 8];
      if (reg_wr && reg_addr == 4'd8) begin
        op = int'(reg_wdata[2:0]);
        if (mode_pre == 0) begin
          m_ie = reg_wdata[3];
          if (op < 2) begin
            m_mode = op + 1; m_idx = 0; m_n = 0;
            m_sp = int'(reg_wdata[31:24]); m_res = int'(reg_wdata[15:14]); m_ns = int'(reg_wdata[8:4]);
          end else m_st[0] = 1;
        end else if (op == 5) begin
          m_mode = 0; m_st[0] = 1;
        end
      end
    end
  end

  // converter stub and per-clock comparison
  int lat = 0, since = -1, nsamp = 0, nstart = 0;
  bit exp_irq;
  always @(negedge clk) begin
    if (rst_n) begin
      exp_irq = (m_st[0] & m_en[0] & m_ie) | (m_st[1] & m_en[1]) | (m_st[2] & m_en[2] & m_ie);
      chk(irq == exp_irq, "R12 irq", irq, exp_irq);
      if (reg_addr == 4'd12) chk(reg_rdata == q.size(), "R6 count", reg_rdata, q.size());
      if (since >= 0) since++;
      conv_done = 0;
      if (lat > 0) begin
        lat--;
        if (lat == 0) begin
          conv_done = 1;
          conv_result = 12'(int'(conv_chan) * 37 + nsamp * 101 + 5);
          nsamp++;
          since = 0;
        end
      end
      if (conv_start) begin
        nstart++;
        chk(conv_chan == tm[m_idx][4:0], "R2 chan", conv_chan, tm[m_idx][4:0]);
        chk(conv_res == m_res, "R5 res", conv_res, m_res);
        if (since >= 0) chk(since == m_sp * DIV + 1, "R4 gap", since, m_sp * DIV + 1);
        lat = 3;
      end
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    @(posedge clk); #1;
    reg_wr = 1; reg_addr = 4'(a); reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 0; reg_addr = 4'd12;
  endtask

  task automatic rdchk(input int a, input int mask, input int exp, input string name);
    @(posedge clk); #1;
    reg_addr = 4'(a); #1;
    chk((reg_rdata & mask) == exp, name, reg_rdata & mask, exp);
    @(posedge clk); #1;
    reg_addr = 4'd12;
  endtask

  task automatic pop_chk(input string name);
    int e;
    @(posedge clk); #1;
    e = (q.size() > 0) ? q[0] : -1;
    reg_addr = 4'd11; reg_rd = 1; #1;
    if (e >= 0) chk(reg_rdata == e, name, reg_rdata, e);
    @(posedge clk); #1;
    reg_rd = 0; reg_addr = 4'd12;
  endtask

  task automatic cmd(input int op, input int sp, input int res, input int ns, input bit ie);
    since = -1;
    wr(8, (sp << 24) | (res << 14) | (ns << 4) | (int'(ie) << 3) | op);
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 3000 && m_mode != 0; k++) @(posedge clk);
    repeat (4) @(posedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk); #1;
    rst_n = 1;
    @(negedge clk);
    chk(reg_rdata == 0, "R1 count", reg_rdata, 0);
    chk(irq == 0, "R1 irq", irq, 0);
    chk(conv_start == 0, "R1 start", conv_start, 0);
    rdchk(9, 7, 0, "R1 status");

    // entries: ch3, ch7, ch18 (end), ch5
    wr(0, 32'h0592_0703);
    wr(10, 1);
    cmd(0, 2, 3, 31, 1);
    wait_idle();
    rdchk(12, 32'hFFFF_FFFF, 3, "R2 walk length");
    rdchk(9, 1, 1, "R11 single done");
    chk(irq == 1, "R12 irq on done", irq, 1);
    for (int k = 0; k < 3; k++) pop_chk("R5 sample 12b");
    rdchk(12, 32'hFFFF_FFFF, 0, "R6 drained");
    wr(9, 1);
    rdchk(9, 1, 0, "R9 w1c");
    chk(irq == 0, "R9 irq cleared", irq, 0);

    // sample limit without end flag reached
    cmd(0, 0, 0, 1, 1);
    wait_idle();
    rdchk(12, 32'hFFFF_FFFF, 2, "R3 limit");
    for (int k = 0; k < 2; k++) pop_chk("R5 sample 6b");
    wr(9, 7);

    // resolutions 8 and 10 with spacing
    cmd(0, 1, 1, 31, 0);
    wait_idle();
    for (int k = 0; k < 3; k++) pop_chk("R5 sample 8b");
    chk(irq == 0, "R12 ie gate", irq, 0);
    wr(9, 7);
    cmd(0, 3, 2, 31, 1);
    repeat (6) @(posedge clk);
    cmd(0, 0, 3, 0, 1);
    cmd(1, 0, 3, 0, 1);
    wait_idle();
    rdchk(12, 32'hFFFF_FFFF, 3, "R11 busy ignore");
    for (int k = 0; k < 3; k++) pop_chk("R5 sample 10b");
    wr(9, 7);

    // immediate completion opcode
    cmd(3, 0, 0, 0, 0);
    rdchk(9, 1, 1, "R11 immediate");
    chk(irq == 0, "R12 ie low", irq, 0);
    rdchk(12, 32'hFFFF_FFFF, 0, "R11 no sample");
    wr(9, 7);

    // continuous with overflow
    wr(10, 6);
    cmd(1, 0, 3, 31, 1);
    for (int k = 0; k < 3000 && !m_st[2]; k++) @(posedge clk);
    rdchk(9, 4, 4, "R10 pass flag");
    for (int k = 0; k < 3000 && !m_st[1]; k++) @(posedge clk);
    rdchk(9, 2, 2, "R8 overflow");
    rdchk(12, 32'hFFFF_FFFF, 32, "R8 full count");
    chk(irq == 1, "R12 overflow irq", irq, 1);
    cmd(5, 0, 0, 0, 0);
    rdchk(9, 1, 1, "R10 stop done");
    begin
      int s0;
      repeat (10) @(posedge clk);
      s0 = nstart;
      repeat (40) @(posedge clk);
      chk(nstart == s0, "R10 halted", nstart, s0);
    end
    rdchk(12, 32'hFFFF_FFFF, 32, "R8 drop kept 32");
    pop_chk("R6 fifo order");
    wr(11, 32'hFFFF_FFFF);
    rdchk(12, 32'hFFFF_FFFF, 0, "R7 flush");
    pop_chk("R6 empty read");
    rdchk(12, 32'hFFFF_FFFF, 0, "R6 empty stays");

    repeat (5) @(posedge clk);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule